// File: doc/BRIEF.md
# Processor Interrupt Recognition Unit

This unit sits inside the processor core and decides whether a pending interrupt is taken. The interrupt controller presents a 3-bit encoded priority level, where 1 is the lowest and 7 the highest. The unit looks at that level only when the core signals an instruction boundary. It compares the level with the 3-bit mask field held in bits 10:8 of the status register, which the unit owns.

Levels 1 to 6 are level-sensitive and the mask can block them. Level 7 cannot be masked and is recognised only on its transition into 7. If that transition happens between boundaries, it is latched and waits for the next boundary. A held level 7 is not taken a second time.

When an interrupt is accepted, the unit does four things in order:
- It pulses an exception request.
- It sets the supervisor bit and clears the trace bit.
- It raises an acknowledge request that carries the accepted level, and waits for a returned 8-bit vector.
- It captures the vector and lifts the mask field to the accepted level.

Top module: `irq_recog_top`

## Requirements
- R1: While in reset and after reset, the status register reads 16'h2700, with supervisor bit 13 set, trace bit 15 clear and mask bits 10:8 equal to 7. Exception request, acknowledge request, vector-valid and the vector are all 0.
- R2: An input level from 1 to 6 that is strictly greater than status bits 10:8 is accepted when the boundary strobe is high. The exception request is high for exactly the one cycle after that clock edge.
- R3: No interrupt is accepted when the level is at or below the mask, or in any cycle where the boundary strobe is low.
- R4: A change of the input level from any other value to 7 is accepted at a boundary whatever the mask holds. A level that stays at 7 is not accepted again until it leaves 7 and returns.
- R5: A transition to 7 between boundaries is held. It is accepted at the next boundary even if the level has dropped by then.
- R6: In the cycle the exception request is high, status bit 13 is 1 and bit 15 is 0. All other status bits keep the value they had before acceptance.
- R7: The acknowledge request is high, carrying the accepted level on its level output, from the cycle after acceptance until the cycle after the vector-valid input is seen. Boundary strobes in that time are not sampled.
- R8: When the vector-valid input is high during an acknowledge, the vector output takes the 8-bit data. Vector-valid-out pulses for one cycle, and status bits 10:8 become the accepted level.
- R9: A status write loads all 16 bits when the unit is idle. It is dropped while an acknowledge is pending, and it is dropped when an acceptance falls in the same cycle.
- R10: Level 0 is never accepted, even with a mask of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | 3 | Encoded interrupt level from the controller |
| boundary_i | input | 1 | Instruction-boundary sample strobe |
| sr_wr_i | input | 1 | Core write strobe for the status register |
| sr_wr_data_i | input | 16 | Status register write value |
| ack_vld_i | input | 1 | Acknowledge data valid |
| ack_data_i | input | 8 | Returned vector byte |
| exc_req_o | output | 1 | One-cycle exception request |
| ack_req_o | output | 1 | Acknowledge fetch request |
| ack_lvl_o | output | 3 | Level being acknowledged |
| sr_o | output | 16 | Current status register |
| vec_o | output | 8 | Captured vector |
| vec_vld_o | output | 1 | One-cycle pulse on vector capture |

## Verification
Two collisions can land on one clock edge: an acceptance and a core write to the status register, and a new transition into level 7 together with the boundary that should sample it. The bench provokes both with directed steps and with random stimulus that puts writes, boundaries and level changes into the same cycle. Each cycle is judged against a bench model in which acceptance beats the write and the same-cycle transition is taken at once.

// File: rtl/irq_recog_pkg.sv
package irq_recog_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam int SR_W  = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } ack_state_e;

  typedef struct packed {
    logic             take;
    logic             nmi;
    logic [LVL_W-1:0] lvl;
  } take_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             consume_i,
  output logic             nmi_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  logic [LVL_W-1:0] prev_q, prev_d;
  logic             pend_q, pend_d;
  logic             rise;

  // transition into the top level since the previous cycle
  always_comb begin
    rise   = (lvl_i == LVL_MAX) && (prev_q != LVL_MAX);
    prev_d = lvl_i;
    pend_d = consume_i ? 1'b0 : (pend_q | rise);
    nmi_o  = pend_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_recog_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          boundary_i,
  input  logic          busy_i,
  input  logic          nmi_i,
  input  logic [LW-1:0] lvl_i,
  input  logic [LW-1:0] mask_i,
  output logic          take_o,
  output logic          take_nmi_o,
  output logic [LW-1:0] take_lvl_o
);
  localparam logic [LW-1:0] LVL_MAX = {LW{1'b1}};

  logic maskable;

  always_comb begin
    maskable   = (lvl_i != '0) && (lvl_i != LVL_MAX) && (lvl_i > mask_i);
    take_o     = boundary_i && !busy_i && (nmi_i || maskable);
    take_nmi_o = take_o && nmi_i;
    take_lvl_o = nmi_i ? LVL_MAX : lvl_i;
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_recog_pkg::*;
#(
  parameter int LW = 3,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [LW-1:0] take_lvl_i,
  input  logic          ack_vld_i,
  input  logic [VW-1:0] ack_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          exc_req_o,
  output logic [LW-1:0] ack_lvl_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_vld_o
);
  ack_state_e    st_q, st_d;
  logic [LW-1:0] lvl_q;
  logic [VW-1:0] vec_q;
  logic          exc_q, vv_q;
  logic          lvl_en, vec_en;

  always_comb begin
    st_d   = st_q;
    done_o = (st_q == ST_ACK) && ack_vld_i;
    lvl_en = take_i;
    vec_en = done_o;
    case (st_q)
      ST_IDLE: if (take_i) st_d = ST_ACK;
      ST_ACK:  if (ack_vld_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      exc_q <= 1'b0;
      vv_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      exc_q <= take_i;
      vv_q  <= done_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else if (lvl_en) lvl_q <= take_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else if (vec_en) vec_q <= ack_data_i;
  end

  assign busy_o    = (st_q == ST_ACK);
  assign exc_req_o = exc_q;
  assign ack_lvl_o = lvl_q;
  assign vec_o     = vec_q;
  assign vec_vld_o = vv_q;
endmodule

// File: rtl/irq_sr_reg.sv
module irq_sr_reg #(
  parameter int          SW        = 16,
  parameter int          LW        = 3,
  parameter int          MASK_LSB  = 8,
  parameter int          SUPV_BIT  = 13,
  parameter int          TRACE_BIT = 15,
  parameter logic [15:0] SR_RST    = 16'h2700
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_i,
  input  logic          done_i,
  input  logic [LW-1:0] done_lvl_i,
  input  logic          busy_i,
  input  logic          wr_i,
  input  logic [SW-1:0] wr_data_i,
  output logic [SW-1:0] sr_o,
  output logic [LW-1:0] mask_o
);
  localparam int MASK_MSB = MASK_LSB + LW - 1;

  logic [SW-1:0] sr_q, sr_d;
  logic          sr_en;
  logic          wr_ok;

  assign wr_ok = wr_i && !busy_i && !enter_i;
  assign sr_en = enter_i || done_i || wr_ok;

  // per-bit next value: entry forces mode bits, completion loads mask field
  for (genvar b = 0; b < SW; b++) begin : g_bit
    if (b == SUPV_BIT) begin : g_supv
      always_comb sr_d[b] = enter_i ? 1'b1 : (wr_ok ? wr_data_i[b] : sr_q[b]);
    end else if (b == TRACE_BIT) begin : g_trace
      always_comb sr_d[b] = enter_i ? 1'b0 : (wr_ok ? wr_data_i[b] : sr_q[b]);
    end else if (b >= MASK_LSB && b <= MASK_MSB) begin : g_mask
      always_comb begin
        if (enter_i)    sr_d[b] = sr_q[b];
        else if (done_i) sr_d[b] = done_lvl_i[b-MASK_LSB];
        else if (wr_ok) sr_d[b] = wr_data_i[b];
        else            sr_d[b] = sr_q[b];
      end
    end else begin : g_plain
      always_comb sr_d[b] = (wr_ok && !enter_i) ? wr_data_i[b] : sr_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SR_RST[SW-1:0];
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr_o   = sr_q;
  assign mask_o = sr_q[MASK_MSB:MASK_LSB];
endmodule

// File: rtl/irq_recog_top.sv
module irq_recog_top
  import irq_recog_pkg::*;
#(
  parameter int          MASK_LSB  = 8,
  parameter int          SUPV_BIT  = 13,
  parameter int          TRACE_BIT = 15,
  parameter logic [15:0] SR_RST    = 16'h2700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             boundary_i,
  input  logic             sr_wr_i,
  input  logic [SR_W-1:0]  sr_wr_data_i,
  input  logic             ack_vld_i,
  input  logic [VEC_W-1:0] ack_data_i,
  output logic             exc_req_o,
  output logic             ack_req_o,
  output logic [LVL_W-1:0] ack_lvl_o,
  output logic [SR_W-1:0]  sr_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  take_t            tk;
  logic             nmi;
  logic             busy;
  logic             done;
  logic [LVL_W-1:0] mask;

  irq_nmi_edge #(.LVL_W(LVL_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (irq_lvl_i),
    .consume_i (tk.nmi),
    .nmi_o     (nmi)
  );

  irq_arbiter #(.LW(LVL_W)) u_arb (
    .boundary_i (boundary_i),
    .busy_i     (busy),
    .nmi_i      (nmi),
    .lvl_i      (irq_lvl_i),
    .mask_i     (mask),
    .take_o     (tk.take),
    .take_nmi_o (tk.nmi),
    .take_lvl_o (tk.lvl)
  );

  irq_ack_fsm #(.LW(LVL_W), .VW(VEC_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (tk.take),
    .take_lvl_i (tk.lvl),
    .ack_vld_i  (ack_vld_i),
    .ack_data_i (ack_data_i),
    .busy_o     (busy),
    .done_o     (done),
    .exc_req_o  (exc_req_o),
    .ack_lvl_o  (ack_lvl_o),
    .vec_o      (vec_o),
    .vec_vld_o  (vec_vld_o)
  );

  irq_sr_reg #(
    .SW(SR_W), .LW(LVL_W), .MASK_LSB(MASK_LSB),
    .SUPV_BIT(SUPV_BIT), .TRACE_BIT(TRACE_BIT), .SR_RST(SR_RST)
  ) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_i    (tk.take),
    .done_i     (done),
    .done_lvl_i (ack_lvl_o),
    .busy_i     (busy),
    .wr_i       (sr_wr_i),
    .wr_data_i  (sr_wr_data_i),
    .sr_o       (sr_o),
    .mask_o     (mask)
  );

  assign ack_req_o = busy;
endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk #(
  parameter int MASK_LSB  = 8,
  parameter int SUPV_BIT  = 13,
  parameter int TRACE_BIT = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  irq_lvl_i,
  input logic        boundary_i,
  input logic        exc_req_o,
  input logic        ack_req_o,
  input logic [2:0]  ack_lvl_o,
  input logic [15:0] sr_o,
  input logic        vec_vld_o
);
  assert_take_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> $past(boundary_i));

  assert_maskable_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_o && ack_lvl_o != 3'd7) |->
      ($past(irq_lvl_i) > $past(sr_o[MASK_LSB +: 3])));

  assert_mode_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (sr_o[SUPV_BIT] && !sr_o[TRACE_BIT]));

  assert_ack_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> ack_req_o);

  assert_ack_lvl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && $past(ack_req_o)) |-> $stable(ack_lvl_o));

  assert_mask_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> (!ack_req_o && sr_o[MASK_LSB +: 3] == ack_lvl_o));

  assert_no_level0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (ack_lvl_o != 3'd0));
endmodule

bind irq_recog_top irq_recog_chk u_chk (.*);

// File: tb/sim_irq_recog_top.sv
module sim_irq_recog_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  irq_lvl_i;
  logic        boundary_i;
  logic        sr_wr_i;
  logic [15:0] sr_wr_data_i;
  logic        ack_vld_i;
  logic [7:0]  ack_data_i;
  logic        exc_req_o;
  logic        ack_req_o;
  logic [2:0]  ack_lvl_o;
  logic [15:0] sr_o;
  logic [7:0]  vec_o;
  logic        vec_vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [15:0] m_sr;
  logic        m_ack, m_pend, m_exc, m_vv;
  logic [2:0]  m_prev, m_lvl;
  logic [7:0]  m_vec;

  irq_recog_top u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enter_sr(logic [15:0] s);
    logic [15:0] r;
    r = s;
    r[13] = 1'b1;
    r[15] = 1'b0;
    return r;
  endfunction

  task automatic compare(string tag);
    chk(tag, "exc_req", exc_req_o, m_exc);
    chk("R7", "ack_req", ack_req_o, m_ack);
    if (m_ack) chk("R7", "ack_lvl", ack_lvl_o, m_lvl);
    chk("R6", "sr", sr_o, m_sr);
    chk("R8", "vec", vec_o, m_vec);
    chk("R8", "vec_vld", vec_vld_o, m_vv);
  endtask

  // one clock: drive at negedge, update model, sample 1ns after posedge
  task automatic step(input logic [2:0] lvl, input logic bnd, input logic wr,
                      input logic [15:0] wd, input logic av, input logic [7:0] ad,
                      input string tag);
    logic rise, nmi, take;
    logic [2:0] tl;
    @(negedge clk);
    irq_lvl_i = lvl; boundary_i = bnd; sr_wr_i = wr; sr_wr_data_i = wd;
    ack_vld_i = av; ack_data_i = ad;
    rise = (lvl == 3'd7) && (m_prev != 3'd7);
    nmi  = m_pend || rise;
    take = !m_ack && bnd &&
           (nmi || (lvl != 3'd0 && lvl != 3'd7 && lvl > m_sr[10:8]));
    tl   = nmi ? 3'd7 : lvl;
    m_vv  = m_ack && av;
    m_exc = take;
    if (take) begin
      m_sr  = enter_sr(m_sr);
      m_ack = 1'b1;
      m_lvl = tl;
    end else if (m_ack && av) begin
      m_vec = ad;
      m_sr[10:8] = m_lvl;
      m_ack = 1'b0;
    end else if (!m_ack && wr) begin
      m_sr = wd;
    end
    m_pend = (take && nmi) ? 1'b0 : (m_pend || rise);
    m_prev = lvl;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic idle(input logic [2:0] lvl, input string tag);
    step(lvl, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9173));
    rst_n = 1'b0; irq_lvl_i = '0; boundary_i = 0; sr_wr_i = 0;
    sr_wr_data_i = '0; ack_vld_i = 0; ack_data_i = '0;
    m_sr = 16'h2700; m_ack = 0; m_pend = 0; m_exc = 0; m_vv = 0;
    m_prev = '0; m_lvl = '0; m_vec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle(3'd0, "R1");

    // R3: mask 7 blocks level 5
    step(3'd5, 1, 0, 0, 0, 0, "R3");
    // R9: write with mask 0
    step(3'd0, 0, 1, 16'h2000, 0, 0, "R9");
    // R10: level 0 never taken
    step(3'd0, 1, 0, 0, 0, 0, "R10");
    // R3: no boundary, no take
    idle(3'd3, "R3");
    // R2: boundary takes level 3
    step(3'd3, 1, 0, 0, 0, 0, "R2");
    // R7: boundary and write ignored while acknowledging
    step(3'd6, 1, 1, 16'h0000, 0, 0, "R7");
    // R8: vector returns, mask becomes 3
    step(3'd3, 0, 0, 0, 1, 8'h45, "R8");
    idle(3'd3, "R8");
    step(3'd3, 1, 0, 0, 0, 0, "R3");
    step(3'd4, 1, 0, 0, 0, 0, "R2");
    step(3'd4, 0, 0, 0, 1, 8'h51, "R8");
    // R9: set mask 7, then R5: edge to 7 between boundaries, dropped later
    step(3'd0, 0, 1, 16'h2700, 0, 0, "R9");
    idle(3'd7, "R5");
    idle(3'd2, "R5");
    step(3'd2, 1, 0, 0, 0, 0, "R5");
    step(3'd2, 0, 0, 0, 1, 8'h1f, "R8");
    // R4: edge with boundary in same cycle, mask 7; steady 7 not retaken
    idle(3'd1, "R4");
    step(3'd7, 1, 0, 0, 0, 0, "R4");
    step(3'd7, 0, 0, 0, 1, 8'h7c, "R8");
    step(3'd7, 1, 0, 0, 0, 0, "R4");
    step(3'd0, 0, 1, 16'h8000, 0, 0, "R9");
    step(3'd7, 1, 0, 0, 0, 0, "R4");
    step(3'd7, 0, 0, 0, 1, 8'h02, "R8");
    // R9: write loses to acceptance in the same cycle
    step(3'd0, 0, 1, 16'h8100, 0, 0, "R9");
    step(3'd5, 1, 1, 16'hffff, 0, 0, "R9");
    step(3'd5, 0, 0, 0, 1, 8'h99, "R8");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  l;
      logic [15:0] wd;
      l  = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 7)) : m_prev;
      wd = 16'($urandom);
      step(l, ($urandom_range(0, 2) == 0), ($urandom_range(0, 15) == 0), wd,
           ($urandom_range(0, 1) == 0), 8'($urandom), "R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule